// File: doc/BRIEF.md
# Asynchronous SRAM Bridge to a Clocked Memory Controller

This block lets logic that speaks the plain asynchronous static-RAM strobe protocol use a clocked memory controller that takes one command at a time through a valid/ready handshake. Every strobe, the address and the write word enter the controller clock domain through two-flop synchronizers. The bridge then decodes a read or a write from the synchronized strobes and issues one single-word command per SRAM cycle. Write commands carry a per-lane byte mask. For reads, the bridge waits for the returned word, registers it, and keeps it on the SRAM data-out bus.

The minimum SRAM cycle time is set by the synchronizer depth plus the controller latency. Callers keep each strobe window long enough to cover both, and keep address and data stable before the strobes fall. No command leaves the bridge until the controller reports that its initialization is done.

Top module: `sramBridge`

## Requirements
- R1: After reset, `sramDout` is 0 and `memCmdValid` is low.
- R2: While `sramWeN` is high, a read is decoded when `sramCeN`, `sramOeN` and at least one of `sramLbN`/`sramUbN` are low. The bridge then issues a command with `memCmdWrite`=0 and `memCmdAddr` equal to `sramAddr`.
- R3: While `sramOeN` is high, a write is decoded when `sramCeN`, `sramWeN` and at least one byte enable are low. The bridge then issues a command with `memCmdWrite`=1, carrying `sramAddr` and `sramDin`.
- R4: `memWrMask` bit 0 guards bits 7:0, selected by `sramLbN`, and bit 1 guards bits 15:8, selected by `sramUbN`. A mask bit of 1 means that lane is left unchanged in memory.
- R5: When both byte enables are high, no command is issued.
- R6: When `sramOeN` and `sramWeN` are both low, the cycle is neither a read nor a write and no command is issued.
- R7: Exactly one command is issued per SRAM cycle, however long the strobes stay active. The decoded condition must fall before another command is accepted. `memCmdValid` drops the cycle after acceptance.
- R8: Until `memInitDone` is high, no command is issued. A strobe that is already active when initialization completes is ignored.
- R9: `sramDout` holds the last read word until the next read completes. Writes do not change it.
- R10: Once `memCmdValid` rises, it stays high with a stable address until `memCmdReady` is high.
- R11: The word presented with `memRdValid` appears on `sramDout` on the following clock. With a controller that accepts within 3 clocks and returns data within 4 clocks, the read word is on `sramDout` within 16 clocks of the strobes falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| sramCeN | input | 1 | Chip enable, active low, asynchronous |
| sramOeN | input | 1 | Output enable, active low, asynchronous |
| sramWeN | input | 1 | Write enable, active low, asynchronous |
| sramLbN | input | 1 | Lower byte enable (bits 7:0), active low |
| sramUbN | input | 1 | Upper byte enable (bits 15:8), active low |
| sramAddr | input | ADDR_W | Word address |
| sramDin | input | 16 | Write word from the SRAM side |
| sramDout | output | 16 | Registered read word |
| memInitDone | input | 1 | Controller initialization complete |
| memCmdValid | output | 1 | Command valid |
| memCmdReady | input | 1 | Controller accepts command |
| memCmdWrite | output | 1 | 1 = write, 0 = read |
| memCmdAddr | output | ADDR_W | Command word address |
| memWrData | output | 16 | Write word |
| memWrMask | output | 2 | Per-lane mask, 1 = lane untouched |
| memRdValid | input | 1 | Read word valid |
| memRdData | input | 16 | Read word from controller |

## Verification
The bench goes after lane masking first. A bridge that inverts or swaps the mask bits would overwrite the byte that should survive a lower-only or upper-only write, so the read-back would show it. Strobes held far longer than one access are checked next: a level-triggered decode would issue repeated commands, and the bench's command count would rise by more than one. Two cases must produce no command at all: a strobe already active when initialization finishes, and a cycle with both output and write enable low. Miscounting either would show up as an extra command or as a memory change. Finally, writes placed between reads confirm that the read register does not pick up controller data outside a completed read.

// File: rtl/sramBridgePkg.sv
package sramBridgePkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [1:0] {
    IDLE      = 2'd0,
    ISSUE     = 2'd1,
    WAIT_RESP = 2'd2,
    DONE      = 2'd3
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic captureData;
  } ctrlStrobes_t;
endpackage

// File: rtl/sramSyncBank.sv
module sramSyncBank #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RST_VAL;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/sramBridgeDatapath.sv
module sramBridgeDatapath
  import sramBridgePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sramCeN,
  input  logic                sramOeN,
  input  logic                sramWeN,
  input  logic                sramLbN,
  input  logic                sramUbN,
  input  logic [ADDR_W-1:0]   sramAddr,
  input  logic [DATA_W-1:0]   sramDin,
  output logic [DATA_W-1:0]   sramDout,
  input  ctrlStrobes_t        strobes,
  input  logic [DATA_W-1:0]   rdData,
  output logic                condActive,
  output logic                condRise,
  output logic                cmdWrite,
  output logic [ADDR_W-1:0]   cmdAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [LANES-1:0]    wrMask
);
  localparam int CTL_W  = 3 + LANES;
  localparam int BUS_W  = CTL_W + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_RST = {{CTL_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUS_W-1:0]  busSync;
  logic              ceS, oeS, weS;
  logic [LANES-1:0]  laneNS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dinS;
  logic              rdCond, wrCond, anyLane, condPrev;

  sramSyncBank #(.W(BUS_W), .STAGES(2), .RST_VAL(BUS_RST)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sramCeN, sramOeN, sramWeN, sramUbN, sramLbN, sramAddr, sramDin}),
    .syncOut(busSync)
  );

  assign {ceS, oeS, weS, laneNS, addrS, dinS} = busSync;

  assign anyLane    = ~&laneNS;
  assign rdCond     = !ceS && !oeS &&  weS && anyLane;
  assign wrCond     = !ceS && !weS &&  oeS && anyLane;
  assign condActive = rdCond || wrCond;
  assign condRise   = condActive && !condPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condPrev <= 1'b0;
      cmdWrite <= 1'b0;
      cmdAddr  <= '0;
      wrData   <= '0;
      wrMask   <= '1;
      sramDout <= '0;
    end else begin
      condPrev <= condActive;
      if (strobes.latchCmd) begin
        cmdWrite <= wrCond;
        cmdAddr  <= addrS;
        wrData   <= dinS;
        wrMask   <= laneNS;
      end
      if (strobes.captureData) sramDout <= rdData;
    end
  end

  // R11: captured word shows on the bus one clock later
  p_capture_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureData |=> sramDout == $past(rdData));
  // R9: read register only moves on a capture
  p_hold_dout_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureData |=> $stable(sramDout));
  // R3: latched write carries the synchronized word
  p_write_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchCmd && wrCond) |=> cmdWrite && wrData == $past(dinS));
endmodule

// File: rtl/sramBridgeControl.sv
module sramBridgeControl
  import sramBridgePkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          initDone,
  input  logic          condActive,
  input  logic          condRise,
  input  logic          cmdWrite,
  input  logic          cmdReady,
  input  logic          rdValid,
  output logic          cmdValid,
  output ctrlStrobes_t  strobes
);
  bridgeState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      IDLE: if (condRise && initDone) begin
        strobes.latchCmd = 1'b1;
        stateD = ISSUE;
      end
      ISSUE: if (cmdReady) stateD = cmdWrite ? DONE : WAIT_RESP;
      WAIT_RESP: if (rdValid) begin
        strobes.captureData = 1'b1;
        stateD = DONE;
      end
      DONE: if (!condActive) stateD = IDLE;
      default: stateD = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end

  assign cmdValid = (stateQ == ISSUE);

  // R10: command held until accepted
  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);
  // R7: one beat per accepted command
  p_single_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdValid);
  // R8: a command only follows a cycle with init complete
  p_init_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(initDone));
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.latchCmd, strobes.captureData}));
endmodule

// File: rtl/sramBridge.sv
module sramBridge
  import sramBridgePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sramCeN,
  input  logic              sramOeN,
  input  logic              sramWeN,
  input  logic              sramLbN,
  input  logic              sramUbN,
  input  logic [ADDR_W-1:0] sramAddr,
  input  logic [15:0]       sramDin,
  output logic [15:0]       sramDout,
  input  logic              memInitDone,
  output logic              memCmdValid,
  input  logic              memCmdReady,
  output logic              memCmdWrite,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic [15:0]       memWrData,
  output logic [1:0]        memWrMask,
  input  logic              memRdValid,
  input  logic [15:0]       memRdData
);
  ctrlStrobes_t strobes;
  logic condActive, condRise;

  sramBridgeDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramLbN(sramLbN), .sramUbN(sramUbN),
    .sramAddr(sramAddr), .sramDin(sramDin), .sramDout(sramDout),
    .strobes(strobes), .rdData(memRdData),
    .condActive(condActive), .condRise(condRise),
    .cmdWrite(memCmdWrite), .cmdAddr(memCmdAddr),
    .wrData(memWrData), .wrMask(memWrMask)
  );

  sramBridgeControl uCtrl (
    .clk(clk), .rstN(rstN),
    .initDone(memInitDone),
    .condActive(condActive), .condRise(condRise),
    .cmdWrite(memCmdWrite), .cmdReady(memCmdReady),
    .rdValid(memRdValid),
    .cmdValid(memCmdValid), .strobes(strobes)
  );

  // R10: address stable while waiting
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memCmdValid && !memCmdReady) |=> $stable(memCmdAddr));
endmodule

// File: tb/tb_sramBridge.sv
module tb_sramBridge;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, lbN = 1'b1, ubN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic initDone = 1'b0;
  logic cmdValid, cmdReady, cmdWrite, rdValid;
  logic [AW-1:0] cmdAddr;
  logic [15:0] wrData, rdData;
  logic [1:0] wrMask;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sramBridge #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN),
    .sramCeN(ceN), .sramOeN(oeN), .sramWeN(weN), .sramLbN(lbN), .sramUbN(ubN),
    .sramAddr(addr), .sramDin(din), .sramDout(dout),
    .memInitDone(initDone),
    .memCmdValid(cmdValid), .memCmdReady(cmdReady), .memCmdWrite(cmdWrite),
    .memCmdAddr(cmdAddr), .memWrData(wrData), .memWrMask(wrMask),
    .memRdValid(rdValid), .memRdData(rdData)
  );

  // controller model: ready after 2 waiting clocks, read data 3 clocks after accept
  logic [15:0] mem [1 << AW];
  int waitCnt = 0;
  int rdCnt = 0;
  logic rdPending = 1'b0;
  logic [15:0] rdWord = '0;
  int cmdCount = 0;
  logic [AW-1:0] lastAddr = '0;

  assign cmdReady = cmdValid && (waitCnt >= 2);
  assign rdValid  = rdPending && (rdCnt == 3);
  assign rdData   = rdValid ? rdWord : 16'hDEAD;

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0000;

  always @(posedge clk) begin
    if (cmdValid && !cmdReady) waitCnt <= waitCnt + 1;
    else waitCnt <= 0;
    if (rdPending) begin
      if (rdCnt == 3) rdPending <= 1'b0;
      else rdCnt <= rdCnt + 1;
    end
    if (cmdValid && cmdReady) begin
      cmdCount <= cmdCount + 1;
      lastAddr <= cmdAddr;
      if (cmdWrite) begin
        if (!wrMask[0]) mem[cmdAddr][7:0]  <= wrData[7:0];
        if (!wrMask[1]) mem[cmdAddr][15:8] <= wrData[15:8];
      end else begin
        rdWord    <= mem[cmdAddr];
        rdPending <= 1'b1;
        rdCnt     <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sramWrite(input logic [AW-1:0] a, input logic [15:0] d,
                           input logic l, input logic u, input logic oe);
    @(negedge clk);
    addr = a; din = d;
    repeat (2) @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = oe; lbN = l; ubN = u;
    repeat (20) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1; lbN = 1'b1; ubN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sramRead(input logic [AW-1:0] a, output logic [15:0] got);
    @(negedge clk);
    addr = a;
    repeat (2) @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; lbN = 1'b0; ubN = 1'b0;
    repeat (16) @(negedge clk);
    got = dout;
    ceN = 1'b1; oeN = 1'b1; lbN = 1'b1; ubN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic testReset();
    check(dout == 16'h0, "R1 dout after reset", dout, 0);
    check(cmdValid == 1'b0, "R1 cmdValid after reset", cmdValid, 0);
  endtask

  task automatic testBeforeInit();
    int c0 = cmdCount;
    sramWrite(8'h10, 16'h1111, 1'b0, 1'b0, 1'b1);
    check(cmdCount == c0, "R8 strobe before init", cmdCount, c0);
    @(negedge clk);
    addr = 8'h11; din = 16'h2222;
    repeat (2) @(negedge clk);
    ceN = 1'b0; weN = 1'b0; lbN = 1'b0; ubN = 1'b0;
    repeat (4) @(negedge clk);
    initDone = 1'b1;
    repeat (20) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; lbN = 1'b1; ubN = 1'b1;
    repeat (8) @(negedge clk);
    check(cmdCount == c0 && mem[8'h11] == 16'h0, "R8 strobe held across init",
          cmdCount, c0);
  endtask

  task automatic testWriteRead();
    logic [15:0] got;
    int c0 = cmdCount;
    sramWrite(8'h05, 16'hA5C3, 1'b0, 1'b0, 1'b1);
    check(mem[8'h05] == 16'hA5C3, "R3 full write", mem[8'h05], 16'hA5C3);
    check(lastAddr == 8'h05, "R10 write address", lastAddr, 8'h05);
    check(cmdCount == c0 + 1, "R7 one command per write", cmdCount, c0 + 1);
    sramRead(8'h05, got);
    check(got == 16'hA5C3, "R2 R11 read back", got, 16'hA5C3);
    check(cmdCount == c0 + 2, "R7 one command per read", cmdCount, c0 + 2);
  endtask

  task automatic testLanes();
    logic [15:0] got;
    sramWrite(8'h20, 16'h1234, 1'b0, 1'b0, 1'b1);
    sramWrite(8'h20, 16'hFFAB, 1'b0, 1'b1, 1'b1);
    check(mem[8'h20] == 16'h12AB, "R4 lower lane only", mem[8'h20], 16'h12AB);
    sramWrite(8'h20, 16'hCDFF, 1'b1, 1'b0, 1'b1);
    check(mem[8'h20] == 16'hCDAB, "R4 upper lane only", mem[8'h20], 16'hCDAB);
    sramRead(8'h20, got);
    check(got == 16'hCDAB, "R4 R2 merged read", got, 16'hCDAB);
  endtask

  task automatic testNoAccess();
    int c0 = cmdCount;
    sramWrite(8'h30, 16'h7777, 1'b1, 1'b1, 1'b1);
    check(cmdCount == c0 && mem[8'h30] == 16'h0, "R5 no byte enable", cmdCount, c0);
    sramWrite(8'h31, 16'h8888, 1'b0, 1'b0, 1'b0);
    check(cmdCount == c0 && mem[8'h31] == 16'h0, "R6 oe and we both low", cmdCount, c0);
  endtask

  task automatic testHoldAndDout();
    logic [15:0] got;
    int c0;
    sramRead(8'h05, got);
    c0 = cmdCount;
    @(negedge clk);
    addr = 8'h40; din = 16'h4444;
    repeat (2) @(negedge clk);
    ceN = 1'b0; weN = 1'b0; lbN = 1'b0; ubN = 1'b0;
    repeat (80) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; lbN = 1'b1; ubN = 1'b1;
    repeat (8) @(negedge clk);
    check(cmdCount == c0 + 1, "R7 long strobe single command", cmdCount, c0 + 1);
    check(dout == 16'hA5C3, "R9 dout kept across write", dout, 16'hA5C3);
    sramRead(8'h40, got);
    check(got == 16'h4444, "R9 dout updates on next read", got, 16'h4444);
    check(lastAddr == 8'h40, "R10 read address", lastAddr, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBeforeInit();
    testWriteRead();
    testLanes();
    testNoAccess();
    testHoldAndDout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule